// File: doc/BRIEF.md
# Two-Wire Interface Control and Status Registers

This block is the register-side logic for a two-wire serial interface. Software sees three byte-wide registers through a simple write strobe with a register select and reads them back on three parallel read buses. The control register holds the interface enable, interrupt enable, acknowledge enable, a start request and a stop request. It also shows a completion flag and a write-collision flag. The status register carries a 5-bit status code and a 2-bit prescaler field. The data register holds the byte that is handed to the bus engine.

The bus engine sits outside the block. It reports an own-address match, a general call, a received byte (with a flag that says the engine is in a receiving mode), completion of an operation (with the status code to publish) and completion of a stop condition. The block answers with the acknowledge decision and a stall level that holds the engine while the completion flag waits for software. It also produces a bus-ownership enable, the start and stop requests, the prescaler bits and a level-sensitive interrupt request.

Top module: `twc_ctrl_regs`

## Requirements
- R1: After synchronous reset the control read is 0x00, the status read is 0xF8, the data read is 0x00, and ack_drive, irq, stall, bus_en, start_req and stop_req are all 0.
- R2: The control read layout is: bit 7 completion flag, bit 6 acknowledge enable, bit 5 start request, bit 4 stop request, bit 3 write-collision flag, bit 2 interface enable, bit 1 always 0, bit 0 interrupt enable. A control write (reg_sel 0) loads bits 6, 5, 4, 2 and 0 on the next edge. Bits 3 and 1 of the written value have no effect.
- R3: While the interface and acknowledge enables are both 1, ack_drive is 1 in the same cycle as an own-address match, as a general call with gcall_en 1, or as a received byte with eng_rx_mode 1. In every other case it is 0.
- R4: While acknowledge enable is 0, ack_drive stays 0 whatever the engine reports. Writing it back to 1 restores acknowledgement from the next cycle.
- R5: A general call with gcall_en 0 does not cause ack_drive. A received byte with eng_rx_mode 0 does not cause it either.
- R6: eng_done sets the completion flag on the next edge while the interface is enabled and stays enabled. A control write with bit 7 at 1 clears the flag, but a set in the same cycle wins. stall equals the flag while the interface is enabled.
- R7: irq is 1 exactly while the completion flag, interrupt enable and global_ie are all 1.
- R8: A data write (reg_sel 2) while the completion flag is 0 sets the collision flag and leaves the data register unchanged.
- R9: A data write while the completion flag is 1 loads the data register and clears the collision flag.
- R10: A control write with bit 2 at 0 drops bus_en, start_req, stop_req, stall and the completion flag on the next edge, and ack_drive then stays 0. eng_done is ignored while the interface is disabled.
- R11: eng_stop_done clears the stop request on the next edge unless a control write in the same cycle sets it again.
- R12: Status bits 7:3 are loaded from eng_status when a completion is accepted and cannot be written by software. Bit 2 reads 0. A status write (reg_sel 1) loads bits 1:0, which drive prescale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data, 3 none |
| reg_wdata | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register read value |
| status_rd | output | 8 | Status register read value |
| data_rd | output | 8 | Data register read value |
| gcall_en | input | 1 | General-call recognition enable |
| global_ie | input | 1 | Global interrupt enable |
| eng_addr_match | input | 1 | Engine: own address received |
| eng_gcall | input | 1 | Engine: general call received |
| eng_byte_rx | input | 1 | Engine: data byte received |
| eng_rx_mode | input | 1 | Engine: in master-receive or slave-receive mode |
| eng_done | input | 1 | Engine: operation complete |
| eng_status | input | 5 | Engine: status code to publish |
| eng_stop_done | input | 1 | Engine: stop condition sent |
| ack_drive | output | 1 | Drive ACK for the current byte |
| irq | output | 1 | Interrupt request level |
| stall | output | 1 | Hold the engine until software clears the flag |
| bus_en | output | 1 | Block owns the SCL and SDA pins |
| start_req | output | 1 | Start condition requested |
| stop_req | output | 1 | Stop condition requested |
| prescale | output | 2 | Prescaler field |

## Verification
The bench targets the priority corners. A completion that lands in the same cycle as a software clear must leave the flag set; a design that gives the clear priority would lose an event and release the stall early. A disable write that arrives alongside a completion or a stop request must win; getting it wrong leaves stall or stop_req high with the pins released. The bench also sends a general call with recognition off and a byte received outside a receiving mode, where a loose ACK decode would acknowledge. Data writes made on either side of the completion flag expose a design that latches the byte on a collision or that never clears the collision flag.

// File: rtl/twc_pkg.sv
package twc_pkg;

    localparam int BYTE_W = 8;
    localparam int STAT_W = 5;
    localparam int PRE_W  = 2;
    localparam int SEL_W  = 2;

    // control register bit positions (software visible layout)
    localparam int CB_DONE = 7;
    localparam int CB_ACK  = 6;
    localparam int CB_STA  = 5;
    localparam int CB_STO  = 4;
    localparam int CB_WCOL = 3;
    localparam int CB_EN   = 2;
    localparam int CB_IE   = 0;

    localparam logic [STAT_W-1:0] STAT_RST = '1;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ack_en;
        logic start;
        logic stop;
        logic en;
        logic ie;
    } ctrl_bits_t;

    typedef struct packed {
        logic addr_match;
        logic gcall;
        logic byte_rx;
        logic rx_mode;
    } rx_evt_t;

    function automatic logic [BYTE_W-1:0] pack_ctrl(ctrl_bits_t c, logic done, logic wcol);
        logic [BYTE_W-1:0] v;
        v          = '0;
        v[CB_DONE] = done;
        v[CB_ACK]  = c.ack_en;
        v[CB_STA]  = c.start;
        v[CB_STO]  = c.stop;
        v[CB_WCOL] = wcol;
        v[CB_EN]   = c.en;
        v[CB_IE]   = c.ie;
        return v;
    endfunction

    function automatic ctrl_bits_t unpack_ctrl(logic [BYTE_W-1:0] w);
        ctrl_bits_t c;
        c.ack_en = w[CB_ACK];
        c.start  = w[CB_STA];
        c.stop   = w[CB_STO];
        c.en     = w[CB_EN];
        c.ie     = w[CB_IE];
        return c;
    endfunction

    function automatic logic ack_wanted(rx_evt_t e, logic gc_en);
        return e.addr_match | (e.gcall & gc_en) | (e.byte_rx & e.rx_mode);
    endfunction

endpackage

// File: rtl/twc_ack_gen.sv
module twc_ack_gen
    import twc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    ack_en,
    input  logic    gc_en,
    input  rx_evt_t evt,
    output logic    ack
);

    logic cause;

    always_comb begin
        cause = ack_wanted(evt, gc_en);
        ack   = en & ack_en & cause;
    end

    // R4
    ack_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_en |-> !ack);

    // R5
    gcall_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!gc_en && !evt.addr_match && !(evt.byte_rx && evt.rx_mode)) |-> !ack);

endmodule

// File: rtl/twc_flag_unit.sv
module twc_flag_unit
    import twc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kill,
    input  logic              set,
    input  logic              clr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              done_q,
    output logic              wcol_q,
    output logic [BYTE_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            wcol_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (kill)
                done_q <= 1'b0;
            else if (set)
                done_q <= 1'b1;
            else if (clr)
                done_q <= 1'b0;

            if (data_wr) begin
                wcol_q <= ~done_q;
                if (done_q)
                    data_q <= wdata;
            end
        end
    end

    // R8
    wcol_set_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !done_q) |=> (wcol_q && $stable(data_q)));

    // R9
    wcol_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && done_q) |=> (!wcol_q && data_q == $past(wdata)));

    // R6
    done_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !done_q);

    // R6
    done_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set && !kill) |=> done_q);

endmodule

// File: rtl/twc_ctrl_regs.sv
module twc_ctrl_regs
    import twc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] ctrl_rd,
    output logic [BYTE_W-1:0] status_rd,
    output logic [BYTE_W-1:0] data_rd,
    input  logic              gcall_en,
    input  logic              global_ie,
    input  logic              eng_addr_match,
    input  logic              eng_gcall,
    input  logic              eng_byte_rx,
    input  logic              eng_rx_mode,
    input  logic              eng_done,
    input  logic [STAT_W-1:0] eng_status,
    input  logic              eng_stop_done,
    output logic              ack_drive,
    output logic              irq,
    output logic              stall,
    output logic              bus_en,
    output logic              start_req,
    output logic              stop_req,
    output logic [PRE_W-1:0]  prescale
);

    localparam int PAD_W = BYTE_W - STAT_W - PRE_W;

    reg_sel_e          sel;
    logic              wr_ctrl, wr_stat, wr_data;
    ctrl_bits_t        cb_q, cb_nxt;
    logic [STAT_W-1:0] code_q;
    logic [PRE_W-1:0]  pre_q;
    logic              done_set, done_clr;
    logic              done_q, wcol_q;
    logic [BYTE_W-1:0] data_q;
    rx_evt_t           evt;

    always_comb begin
        sel     = reg_sel_e'(reg_sel);
        wr_ctrl = reg_we && (sel == SEL_CTRL);
        wr_stat = reg_we && (sel == SEL_STAT);
        wr_data = reg_we && (sel == SEL_DATA);
    end

    // next control bits: stop completion first, software write overrides,
    // a cleared enable forces the requests low
    always_comb begin
        cb_nxt = cb_q;
        if (eng_stop_done)
            cb_nxt.stop = 1'b0;
        if (wr_ctrl)
            cb_nxt = unpack_ctrl(reg_wdata);
        if (!cb_nxt.en) begin
            cb_nxt.start = 1'b0;
            cb_nxt.stop  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cb_q <= '0;
        else
            cb_q <= cb_nxt;
    end

    assign done_set = eng_done & cb_q.en & cb_nxt.en;
    assign done_clr = wr_ctrl & reg_wdata[CB_DONE];

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= STAT_RST;
            pre_q  <= '0;
        end else begin
            if (done_set)
                code_q <= eng_status;
            if (wr_stat)
                pre_q <= reg_wdata[PRE_W-1:0];
        end
    end

    twc_flag_unit u_flags (
        .clk     (clk),
        .rst     (rst),
        .kill    (~cb_nxt.en),
        .set     (done_set),
        .clr     (done_clr),
        .data_wr (wr_data),
        .wdata   (reg_wdata),
        .done_q  (done_q),
        .wcol_q  (wcol_q),
        .data_q  (data_q)
    );

    always_comb begin
        evt.addr_match = eng_addr_match;
        evt.gcall      = eng_gcall;
        evt.byte_rx    = eng_byte_rx;
        evt.rx_mode    = eng_rx_mode;
    end

    twc_ack_gen u_ack (
        .clk    (clk),
        .rst    (rst),
        .en     (cb_q.en),
        .ack_en (cb_q.ack_en),
        .gc_en  (gcall_en),
        .evt    (evt),
        .ack    (ack_drive)
    );

    always_comb begin
        ctrl_rd   = pack_ctrl(cb_q, done_q, wcol_q);
        status_rd = {code_q, {PAD_W{1'b0}}, pre_q};
        data_rd   = data_q;
        irq       = done_q & cb_q.ie & global_ie;
        stall     = done_q & cb_q.en;
        bus_en    = cb_q.en;
        start_req = cb_q.start;
        stop_req  = cb_q.stop;
        prescale  = pre_q;
    end

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stall && ctrl_rd[CB_IE] && global_ie));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !reg_wdata[CB_EN]) |=>
            (!bus_en && !start_req && !stop_req && !stall && !ack_drive));

    // R12
    status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !done_set) |=>
            ($stable(status_rd[BYTE_W-1:PRE_W]) && prescale == $past(reg_wdata[PRE_W-1:0])));

    // R11
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_stop_done && !wr_ctrl) |=> !stop_req);

endmodule

// File: tb/twc_ctrl_regs_tb.sv
`timescale 1ns/1ps
module twc_ctrl_regs_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd3;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctrl_rd, status_rd, data_rd;
    logic       gcall_en = 1'b0, global_ie = 1'b0;
    logic       eng_addr_match = 1'b0, eng_gcall = 1'b0, eng_byte_rx = 1'b0;
    logic       eng_rx_mode = 1'b0, eng_done = 1'b0, eng_stop_done = 1'b0;
    logic [4:0] eng_status = 5'd0;
    logic       ack_drive, irq, stall, bus_en, start_req, stop_req;
    logic [1:0] prescale;

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    bit m_en, m_ie, m_ack, m_sta, m_sto, m_done, m_wcol;
    bit [4:0] m_code = 5'h1F;
    bit [1:0] m_pre;
    bit [7:0] m_data;

    always #2 clk = ~clk;

    twc_ctrl_regs u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctrl_rd(ctrl_rd), .status_rd(status_rd), .data_rd(data_rd),
        .gcall_en(gcall_en), .global_ie(global_ie),
        .eng_addr_match(eng_addr_match), .eng_gcall(eng_gcall), .eng_byte_rx(eng_byte_rx),
        .eng_rx_mode(eng_rx_mode), .eng_done(eng_done), .eng_status(eng_status),
        .eng_stop_done(eng_stop_done),
        .ack_drive(ack_drive), .irq(irq), .stall(stall), .bus_en(bus_en),
        .start_req(start_req), .stop_req(stop_req), .prescale(prescale)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit e_ack;
        e_ack = m_en && m_ack &&
                (eng_addr_match || (eng_gcall && gcall_en) || (eng_byte_rx && eng_rx_mode));
        cmp("R2 R6 R8 R9 R10", "ctrl_rd",
            int'(ctrl_rd), int'({m_done, m_ack, m_sta, m_sto, m_wcol, m_en, 1'b0, m_ie}));
        cmp("R12", "status_rd", int'(status_rd), int'({m_code, 1'b0, m_pre}));
        cmp("R8 R9", "data_rd", int'(data_rd), int'(m_data));
        cmp("R3 R4 R5", "ack_drive", int'(ack_drive), int'(e_ack));
        cmp("R7", "irq", int'(irq), int'(m_done && m_ie && global_ie));
        cmp("R6", "stall", int'(stall), int'(m_done && m_en));
        cmp("R10", "bus_en", int'(bus_en), int'(m_en));
        cmp("R10", "start_req", int'(start_req), int'(m_sta));
        cmp("R11", "stop_req", int'(stop_req), int'(m_sto));
        cmp("R12", "prescale", int'(prescale), int'(m_pre));
    endtask

    task automatic model_edge();
        bit wc, ws, wd, n_en, n_sto, n_sta, n_ack, n_ie, acc;
        wc = reg_we && reg_sel == 2'd0;
        ws = reg_we && reg_sel == 2'd1;
        wd = reg_we && reg_sel == 2'd2;
        n_en  = wc ? reg_wdata[2] : m_en;
        n_ie  = wc ? reg_wdata[0] : m_ie;
        n_ack = wc ? reg_wdata[6] : m_ack;
        n_sta = wc ? reg_wdata[5] : m_sta;
        n_sto = eng_stop_done ? 1'b0 : m_sto;
        if (wc) n_sto = reg_wdata[4];
        if (!n_en) begin n_sta = 0; n_sto = 0; end
        acc = eng_done && m_en && n_en;
        if (wd) begin
            if (m_done) m_data = reg_wdata;
            m_wcol = !m_done;
        end
        if (!n_en) m_done = 0;
        else if (acc) m_done = 1;
        else if (wc && reg_wdata[7]) m_done = 0;
        if (acc) m_code = eng_status;
        if (ws) m_pre = reg_wdata[1:0];
        m_en = n_en; m_ie = n_ie; m_ack = n_ack; m_sta = n_sta; m_sto = n_sto;
    endtask

    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        reg_we = 0; reg_sel = 2'd3; reg_wdata = 8'h00;
        eng_addr_match = 0; eng_gcall = 0; eng_byte_rx = 0; eng_rx_mode = 0;
        eng_done = 0; eng_stop_done = 0; eng_status = 5'd0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        reg_we = 1; reg_sel = s; reg_wdata = d;
        step();
        reg_we = 0; reg_sel = 2'd3;
    endtask

    task automatic done_evt(input logic [4:0] code);
        eng_done = 1; eng_status = code;
        step();
        eng_done = 0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset values
        cmp("R1", "ctrl_rd reset", int'(ctrl_rd), 8'h00);
        cmp("R1", "status_rd reset", int'(status_rd), 8'hF8);
        cmp("R1", "data_rd reset", int'(data_rd), 8'h00);
        cmp("R1", "outputs reset",
            int'({ack_drive, irq, stall, bus_en, start_req, stop_req}), 0);
        step();

        // R2 layout, reserved and read-only bits
        wr(2'd0, 8'h45); step();
        wr(2'd0, 8'hFF); step();
        wr(2'd0, 8'h44); step();

        // R3 acknowledge causes
        eng_addr_match = 1; step(); eng_addr_match = 0;
        gcall_en = 1; eng_gcall = 1; step();
        // R5 general call ignored with recognition off
        gcall_en = 0; step(); eng_gcall = 0;
        eng_byte_rx = 1; eng_rx_mode = 1; step();
        eng_rx_mode = 0; step(); eng_byte_rx = 0;
        // R4 acknowledge disabled, then restored
        wr(2'd0, 8'h04);
        eng_addr_match = 1; eng_byte_rx = 1; eng_rx_mode = 1; step();
        eng_byte_rx = 0; eng_rx_mode = 0;
        wr(2'd0, 8'h44); step(); eng_addr_match = 0;

        // R8 collision with flag low
        wr(2'd2, 8'hA5); step();
        // R6 completion, R12 status code
        done_evt(5'h0C); step();
        // R7 interrupt level
        wr(2'd0, 8'h45); step();
        global_ie = 1; step();
        // R9 data write with flag high
        wr(2'd2, 8'h3C); step();
        // R6 clear
        wr(2'd0, 8'hC5); step();
        // R6 set wins over same-cycle clear
        eng_done = 1; eng_status = 5'h15; wr(2'd0, 8'hC5); eng_done = 0; step();
        wr(2'd0, 8'hC5); step();

        // R11 stop request and its completion
        wr(2'd0, 8'h55); step();
        eng_stop_done = 1; step(); eng_stop_done = 0;
        wr(2'd0, 8'h55);
        eng_stop_done = 1; wr(2'd0, 8'h55); eng_stop_done = 0; step();

        // R12 status write
        wr(2'd1, 8'hFF); step();
        wr(2'd1, 8'h02); step();

        // R10 abort while busy
        wr(2'd0, 8'h75); done_evt(5'h08);
        eng_done = 1; wr(2'd0, 8'h00); eng_done = 0; step();
        eng_addr_match = 1; step(); eng_addr_match = 0;
        done_evt(5'h03); step();

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            reg_we = (r < 35);
            reg_sel = 2'($urandom % 4);
            reg_wdata = 8'($urandom);
            if ($urandom % 10 != 0) reg_wdata[2] = 1'b1;
            gcall_en = 1'($urandom);
            global_ie = 1'($urandom);
            eng_addr_match = ($urandom % 4 == 0);
            eng_gcall = ($urandom % 4 == 0);
            eng_byte_rx = ($urandom % 3 == 0);
            eng_rx_mode = 1'($urandom);
            eng_done = ($urandom % 5 == 0);
            eng_status = 5'($urandom);
            eng_stop_done = ($urandom % 6 == 0);
            step();
        end
        idle();
        step();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule